// File: doc/BRIEF.md
# Ordering-Gated Write-Back Buffer

This block holds dirty lines that a first-level data cache has evicted or flushed, until the next cache level takes them. Each stored line carries its address, its data, a flag saying whether it must respect persist ordering, and the snapshot of the write-combining queue's tail position that was attached to the line when it was written. Lines without the flag are forwarded as soon as the next level accepts them. Flagged lines are held until the most recent acknowledge-head value from the write-combining queue is greater than or equal to their snapshot. That condition means that every non-temporal write queued before the line has been acknowledged.

The block is checked for eligibility at two points. Every time a new acknowledge-head value arrives, all stored entries are compared with it. A new entry is compared with the current value on the cycle it is allocated. Once an entry is marked eligible, the mark stays until the entry leaves. Storage is a compacting queue, so slot 0 always holds the oldest entry. The oldest eligible entry is presented on the write-back port, and one entry leaves per handshake.

An occupancy state machine with three states, EMPTY, PART and FULL, drives the ready signal toward the cache. Its transitions are:
- fill: EMPTY to PART, on an allocation.
- top-off: PART to FULL, when the last free slot is taken.
- release: FULL to PART, on a departure.
- drain-out: PART to EMPTY, when the last entry leaves.

Top module: `wbg_order_buf`

## Requirements
- R1: After reset, `wb_valid` is 0 and `alloc_ready` is 1.
- R2: An accepted entry with `alloc_ordered`=0 is offered on `wb_valid`/`wb_addr`/`wb_data` from the cycle after its allocation.
- R3: An entry with `alloc_ordered`=1 is never offered while its snapshot is greater than every acknowledge-head value received so far.
- R4: In a cycle where `ack_valid`=1, every stored ordered entry with snapshot <= `ack_value` becomes eligible. The entry is offered from the following cycle.
- R5: An ordered entry is compared when it is allocated. The comparison value is `ack_value` if `ack_valid` is high in that cycle, otherwise the last value received (0 after reset). If the snapshot is less than or equal to that value, the entry is offered from the next cycle.
- R6: The eligible mark is sticky. A later, smaller acknowledge-head value (including 0) does not withdraw an entry that was already eligible.
- R7: Among eligible entries, the one allocated earliest is offered first. Exactly one entry leaves per cycle in which `wb_valid` and `wb_ready` are both 1.
- R8: While `wb_ready` is 0, no entry leaves, and `wb_valid` stays 1 once it is 1.
- R9: With all DEPTH entries valid, `alloc_ready` is 0 and `alloc_valid` has no effect. `alloc_ready` returns to 1 in the cycle after a departure.
- R10: The comparison between snapshot and acknowledge-head is unsigned over all SNAP_W bits, including the wrap-count bits above the index bits.
- R11: Entries that are eligible on arrival leave in allocation order. This also holds when an allocation and a departure happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Cache presents a line to store |
| alloc_ready | output | 1 | A free slot exists |
| alloc_addr | input | ADDR_W | Line address |
| alloc_data | input | DATA_W | Line data |
| alloc_ordered | input | 1 | Line must respect persist ordering |
| alloc_snap | input | SNAP_W | Tail snapshot attached to the line |
| ack_valid | input | 1 | A new acknowledge-head value is present |
| ack_value | input | SNAP_W | Acknowledge-head value from the write-combining queue |
| wb_valid | output | 1 | An eligible line is offered to the next level |
| wb_ready | input | 1 | Next level accepts a line this cycle |
| wb_addr | output | ADDR_W | Address of the offered line |
| wb_data | output | DATA_W | Data of the offered line |

## Verification
A wrong eligibility mark appears at the ports within one cycle. The affected line is either offered too early, which can be seen on `wb_valid` in the cycle after the acknowledge-head value or the allocation that set the mark, or it never appears at all. A corrupted compaction or selection appears as a wrong `wb_addr` at the next handshake. A wrong occupancy state appears as an `alloc_ready` level that does not match the number of lines written minus the number drained. The snapshot/acknowledge sweep covers every pair of 6-bit values, so any error in the comparison boundary surfaces immediately.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/wbg_snap_le.sv
module wbg_snap_le #(
    parameter int W = 6
) (
    input  logic [W-1:0] snap,
    input  logic [W-1:0] head,
    output logic         le
);
    // unsigned over the whole width, wrap-count bits included
    assign le = (snap <= head);
endmodule

// File: rtl/wbg_pick.sv
module wbg_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign found = |req;
endmodule

// File: rtl/wbg_occ_fsm.sv
module wbg_occ_fsm
    import wbg_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] cnt,
    output occ_state_e    state,
    output logic          can_accept
);
    occ_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: if (push) state_d = OCC_PART;                        // fill
            OCC_PART: begin
                if (push && !pop && cnt == CW'(N - 1)) state_d = OCC_FULL;  // top-off
                else if (pop && !push && cnt == CW'(1)) state_d = OCC_EMPTY; // drain-out
            end
            OCC_FULL: if (pop && !push) state_d = OCC_PART;                 // release
            default: state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            OCC_FULL: can_accept = 1'b0;
            default:  can_accept = 1'b1;
        endcase
    end

    assign state = state_q;

    // R9
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) |-> !push);
endmodule

// File: rtl/wbg_order_buf.sv
module wbg_order_buf
    import wbg_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SNAP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              alloc_ordered,
    input  logic [SNAP_W-1:0] alloc_snap,
    input  logic              ack_valid,
    input  logic [SNAP_W-1:0] ack_value,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [SNAP_W-1:0] snap_q [DEPTH];
    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [SNAP_W-1:0] snap_d [DEPTH];
    logic [DEPTH-1:0]  ord_q, ord_d, mark_q, mark_d, mark_upd, hit, vld, elig;
    logic [CW-1:0]     cnt_q, cnt_d, cnt_mid;
    logic [SNAP_W-1:0] ack_q, ack_eff, ack_max_q;
    logic              alloc_hit, acc, fire, found;
    logic [IW-1:0]     pick_idx;
    occ_state_e        occ;

    assign ack_eff = ack_valid ? ack_value : ack_q;

    // one comparator per slot against the arriving value
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        wbg_snap_le #(.W(SNAP_W)) cmp_i (
            .snap(snap_q[g]), .head(ack_value), .le(hit[g]));
        assign vld[g]      = (CW'(g) < cnt_q);
        assign mark_upd[g] = mark_q[g] | (ack_valid & hit[g]);
        assign elig[g]     = vld[g] & (~ord_q[g] | mark_q[g]);
    end

    wbg_snap_le #(.W(SNAP_W)) cmp_alloc_i (
        .snap(alloc_snap), .head(ack_eff), .le(alloc_hit));

    wbg_pick #(.N(DEPTH), .IW(IW)) pick_i (
        .req(elig), .found(found), .idx(pick_idx));

    wbg_occ_fsm #(.N(DEPTH), .CW(CW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .push(acc), .pop(fire), .cnt(cnt_q),
        .state(occ), .can_accept(alloc_ready));

    assign wb_valid = found;
    assign wb_addr  = addr_q[pick_idx];
    assign wb_data  = data_q[pick_idx];
    assign fire     = found & wb_ready;
    assign acc      = alloc_valid & alloc_ready;
    assign cnt_mid  = cnt_q - CW'(fire);
    assign cnt_d    = cnt_mid + CW'(acc);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (fire && i >= int'(pick_idx) && i < DEPTH - 1) begin
                addr_d[i] = addr_q[i + 1];
                data_d[i] = data_q[i + 1];
                snap_d[i] = snap_q[i + 1];
                ord_d[i]  = ord_q[i + 1];
                mark_d[i] = mark_upd[i + 1];
            end else begin
                addr_d[i] = addr_q[i];
                data_d[i] = data_q[i];
                snap_d[i] = snap_q[i];
                ord_d[i]  = ord_q[i];
                mark_d[i] = mark_upd[i];
            end
        end
        if (acc) begin
            addr_d[cnt_mid[IW-1:0]] = alloc_addr;
            data_d[cnt_mid[IW-1:0]] = alloc_data;
            snap_d[cnt_mid[IW-1:0]] = alloc_snap;
            ord_d[cnt_mid[IW-1:0]]  = alloc_ordered;
            mark_d[cnt_mid[IW-1:0]] = alloc_hit;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) >= cnt_d) begin
                ord_d[i]  = 1'b0;
                mark_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ord_q     <= '0;
            mark_q    <= '0;
            ack_q     <= '0;
            ack_max_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            ord_q  <= ord_d;
            mark_q <= mark_d;
            if (ack_valid) begin
                ack_q <= ack_value;
                if (ack_value > ack_max_q) ack_max_q <= ack_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= addr_d[i];
            data_q[i] <= data_d[i];
            snap_q[i] <= snap_d[i];
        end
    end

    // R3
    ordered_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ord_q[pick_idx]) |-> (snap_q[pick_idx] <= ack_max_q));

    // R8
    held_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> wb_valid);

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DEPTH)) |-> (!alloc_ready && occ == OCC_FULL));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R1
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_EMPTY) |-> (!wb_valid && cnt_q == '0));
endmodule

// File: tb/wbg_order_buf_tb_top.sv
module wbg_order_buf_tb_top;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0, alloc_ready, alloc_ordered = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic [DW-1:0] alloc_data = '0;
    logic [SW-1:0] alloc_snap = '0;
    logic ack_valid = 1'b0;
    logic [SW-1:0] ack_value = '0;
    logic wb_valid, wb_ready = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wbg_order_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .SNAP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .alloc_ordered(alloc_ordered), .alloc_snap(alloc_snap),
        .ack_valid(ack_valid), .ack_value(ack_value),
        .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data));

    function automatic logic [DW-1:0] dpat(input logic [AW-1:0] a);
        return {~a, a} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_ack(input logic [SW-1:0] v);
        ack_valid = 1'b1;
        ack_value = v;
        step();
        ack_valid = 1'b0;
    endtask

    task automatic push(input logic [AW-1:0] a, input bit ord, input logic [SW-1:0] s);
        alloc_valid   = 1'b1;
        alloc_addr    = a;
        alloc_data    = dpat(a);
        alloc_ordered = ord;
        alloc_snap    = s;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic drain(input logic [AW-1:0] a, input string req);
        chk(wb_valid == 1'b1, req, wb_valid, 1);
        chk(wb_addr == a, req, wb_addr, a);
        chk(wb_data == dpat(a), req, wb_data, dpat(a));
        wb_ready = 1'b1;
        step();
        wb_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(wb_valid == 1'b0, "R1", wb_valid, 0);
        chk(alloc_ready == 1'b1, "R1", alloc_ready, 1);

        // R2 and R11: unordered lines in order, plus simultaneous push and drain
        push(16'h0300, 1'b0, 6'd63);
        chk(wb_valid && wb_addr == 16'h0300, "R2", wb_addr, 16'h0300);
        push(16'h0301, 1'b0, 6'd0);
        push(16'h0302, 1'b0, 6'd9);
        drain(16'h0300, "R11");
        alloc_valid = 1'b1; alloc_addr = 16'h0303; alloc_data = dpat(16'h0303);
        alloc_ordered = 1'b0; alloc_snap = '0;
        drain(16'h0301, "R11");
        alloc_valid = 1'b0;
        drain(16'h0302, "R11");
        drain(16'h0303, "R11");
        chk(wb_valid == 1'b0, "R11", wb_valid, 0);

        // R7 and R8: oldest eligible first, held while not ready
        send_ack(6'd5);
        push(16'h0200, 1'b1, 6'd20);
        push(16'h0201, 1'b0, 6'd0);
        push(16'h0202, 1'b1, 6'd3);
        chk(wb_addr == 16'h0201, "R7", wb_addr, 16'h0201);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(wb_valid && wb_addr == 16'h0201, "R8", wb_addr, 16'h0201);
        end
        drain(16'h0201, "R7");
        chk(wb_addr == 16'h0202, "R7", wb_addr, 16'h0202);
        drain(16'h0202, "R7");
        chk(wb_valid == 1'b0, "R3", wb_valid, 0);
        send_ack(6'd20);
        drain(16'h0200, "R4");
        chk(wb_valid == 1'b0, "R7", wb_valid, 0);

        // R9: fill, ignore extra requests, recover after one departure
        send_ack(6'd0);
        for (int k = 0; k < DEPTH; k++) begin
            chk(alloc_ready == 1'b1, "R9", alloc_ready, 1);
            push(AW'(16'h0100 + k), 1'b1, 6'd40);
        end
        chk(alloc_ready == 1'b0, "R9", alloc_ready, 0);
        alloc_valid = 1'b1; alloc_addr = 16'hDEAD; alloc_data = dpat(16'hDEAD);
        alloc_ordered = 1'b0;
        step(); step();
        alloc_valid = 1'b0;
        chk(alloc_ready == 1'b0, "R9", alloc_ready, 0);
        chk(wb_valid == 1'b0, "R9", wb_valid, 0);
        send_ack(6'd40);
        drain(16'h0100, "R9");
        chk(alloc_ready == 1'b1, "R9", alloc_ready, 1);
        for (int k = 1; k < DEPTH; k++) drain(AW'(16'h0100 + k), "R9");
        chk(wb_valid == 1'b0, "R9", wb_valid, 0);

        // R3 R4 R5 R6 R10: every snapshot against every acknowledge value
        for (int s = 0; s < 64; s++) begin
            for (int a = 0; a < 64; a++) begin
                logic [AW-1:0] tag;
                tag = AW'(s * 64 + a);
                send_ack(SW'(a));
                push(tag, 1'b1, SW'(s));
                chk(wb_valid == (s <= a), "R5 R10", wb_valid, (s <= a));
                if (s > a) begin
                    send_ack(SW'(s - 1));
                    chk(wb_valid == 1'b0, "R3 R10", wb_valid, 0);
                    send_ack(SW'(s));
                    chk(wb_valid == 1'b1, "R4", wb_valid, 1);
                end
                send_ack(6'd0);
                chk(wb_valid == 1'b1, "R6", wb_valid, 1);
                drain(tag, "R6");
                chk(wb_valid == 1'b0, "R7", wb_valid, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule